// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the device side of a transmit queue that software and hardware share through memory. Software places 16-byte descriptors in a circular array, each pointing at a buffer of frame bytes. It then moves a tail index forward. The engine owns the head index. It reads the descriptor at head, sends the referenced bytes out on a byte stream with a valid/ready handshake, optionally marks the descriptor as done in memory, and advances head. Work stops when head reaches tail.

A small register port sets the ring base address, the ring length in bytes, the head and tail indices, and an enable bit. The memory port is a simple synchronous port. A read returns data in the cycle after the request. A write carries per-byte enables. Completion is reported only through the done flag that the engine writes into the descriptor, and only when that descriptor asked for it.

Top module: `txring_engine`

## Requirements
- R1: After reset, every register reads zero, out_valid is low and no memory request is issued.
- R2: Register addresses are: 0 control (bit 0 is transmit enable), 1 ring base byte address, 2 ring length in bytes, 3 head index, 4 tail index. The length register stores only multiples of 128, so its low 7 bits always read zero. The ring holds length/16 descriptors.
- R3: While the enable bit is clear, a tail write is stored and reads back, but no descriptor is fetched, nothing is streamed and head does not move.
- R4: When enabled, the engine processes descriptors in index order from head up to, but not including, tail. It stops once head equals tail. Tail is a descriptor index, not a byte offset.
- R5: Descriptor k sits at base + 16*k. Its fields are: buffer address in bytes 0 to 7 (the low 32 bits are used), byte length in bytes 8 to 9, command in byte 11, status in byte 12. Memory is little-endian with 32-bit words.
- R6: The buffer bytes leave in ascending address order, one per cycle in which out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_data and out_last hold their values.
- R7: out_last is high with the final byte of a descriptor whose command bit 0 (end of packet) is set, and at no other time.
- R8: When command bit 3 (report status) is set, the engine writes status bit 0 (done) with a single-byte write (byte enable 0001) to the word at offset 12. This happens only after the descriptor's final byte has been accepted. A descriptor without that bit gets no write.
- R9: Head advances by one after each descriptor and wraps from the last ring entry to entry 0.
- R10: A descriptor of length zero streams nothing but is still consumed. It is marked done if it asks for a report.
- R11: Software may write head only while the enable bit is clear and the engine is idle. A head write at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_be | output | 4 | Memory write byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream byte accepted |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a frame |

## Verification
A wrong head index shows at once as bytes from the wrong buffer on the stream, or as a done write at the wrong descriptor address. A wrong head index also shows, once the ring drains, as a head readback that differs from tail. A byte counter or lane-select error appears on the first mismatching streamed byte. A wrong end-of-packet decode appears on that descriptor's final byte. A status write that comes too early or goes to the wrong place is caught at the write itself, by comparing the number of bytes accepted so far against the descriptor's cumulative end. The bench uses random ready back-pressure, random lengths including zero, unaligned buffers and several trips around the ring.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_F0, ST_F1, ST_F2, ST_F3,
    ST_BREQ, ST_BCAP, ST_BOUT, ST_WB, ST_ADV
  } txr_state_e;

  localparam int CMD_EOP  = 0;
  localparam int CMD_RS   = 3;
  localparam int STS_DONE = 0;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_LEN  = 3'd2;
  localparam logic [2:0] RA_HEAD = 3'd3;
  localparam logic [2:0] RA_TAIL = 3'd4;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            busy,
  input  logic            head_adv,
  output logic            en,
  output logic [AW-1:0]   ring_base,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail
);
  localparam int LEN_LSB = 7;

  logic            en_q, en_d;
  logic [AW-1:0]   base_q, base_d, len_q, len_d;
  logic [IDXW-1:0] head_q, head_d, tail_q, tail_d, entries;
  logic [IDXW:0]   head_inc;

  assign entries  = len_q[IDXW+3:4];
  assign head_inc = {1'b0, head_q} + 1'b1;

  always_comb begin
    en_d   = en_q;
    base_d = base_q;
    len_d  = len_q;
    tail_d = tail_q;
    head_d = head_q;
    if (reg_wr) begin
      case (reg_addr)
        RA_CTRL: en_d   = reg_wdata[0];
        RA_BASE: base_d = reg_wdata[AW-1:0];
        RA_LEN:  len_d  = {reg_wdata[AW-1:LEN_LSB], {LEN_LSB{1'b0}}};
        RA_TAIL: tail_d = reg_wdata[IDXW-1:0];
        default: ;
      endcase
    end
    if (head_adv)
      head_d = (head_inc == {1'b0, entries}) ? '0 : head_inc[IDXW-1:0];
    else if (reg_wr && reg_addr == RA_HEAD && !en_q && !busy)
      head_d = reg_wdata[IDXW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      en_q   <= en_d;
      base_q <= base_d;
      len_q  <= len_d;
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata[0] = en_q;
      RA_BASE: reg_rdata = 32'(base_q);
      RA_LEN:  reg_rdata = 32'(len_q);
      RA_HEAD: reg_rdata = 32'(head_q);
      RA_TAIL: reg_rdata = 32'(tail_q);
      default: ;
    endcase
  end

  assign en        = en_q;
  assign ring_base = base_q;
  assign head      = head_q;
  assign tail      = tail_q;

  // R4: the engine never consumes from an empty ring
  p_adv_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    head_adv |-> head_q != tail_q);
  // R9: head stays inside the ring when it advances
  p_head_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    head_adv |-> head_q < entries);
  // R11: a head write while enabled changes nothing
  p_head_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_HEAD && en_q && !head_adv) |=> $stable(head_q));
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 16,
  parameter int LW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [AW-1:0]   ring_base,
  input  logic [IDXW-1:0] head,
  input  logic [IDXW-1:0] tail,
  output logic            head_adv,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_data,
  output logic            out_last
);
  localparam int DESC_SHIFT = 4;

  txr_state_e    st_q, st_d;
  logic [AW-1:0] buf_q, buf_d, desc_addr, byte_addr;
  logic [LW-1:0] len_q, len_d, cnt_q, cnt_d;
  logic [7:0]    cmd_q, cmd_d, byte_q, byte_d;
  logic          fin;

  assign desc_addr = ring_base + (AW'(head) << DESC_SHIFT);
  assign byte_addr = buf_q + AW'(cnt_q);
  assign fin       = (cnt_q == len_q - 1'b1);

  always_comb begin
    st_d      = st_q;
    buf_d     = buf_q;
    len_d     = len_q;
    cmd_d     = cmd_q;
    cnt_d     = cnt_q;
    byte_d    = byte_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_be    = 4'hF;
    mem_wdata = '0;
    out_valid = 1'b0;
    head_adv  = 1'b0;
    case (st_q)
      ST_IDLE: if (en && head != tail) st_d = ST_F0;
      ST_F0: begin
        mem_req = 1'b1;
        st_d    = ST_F1;
      end
      ST_F1: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(4);
        buf_d    = mem_rdata[AW-1:0];
        st_d     = ST_F2;
      end
      ST_F2: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(8);
        st_d     = ST_F3;
      end
      ST_F3: begin
        len_d = mem_rdata[LW-1:0];
        cmd_d = mem_rdata[31:24];
        cnt_d = '0;
        if (mem_rdata[LW-1:0] != '0) st_d = ST_BREQ;
        else if (mem_rdata[24+CMD_RS]) st_d = ST_WB;
        else st_d = ST_ADV;
      end
      ST_BREQ: begin
        mem_req  = 1'b1;
        mem_addr = {byte_addr[AW-1:2], 2'b00};
        st_d     = ST_BCAP;
      end
      ST_BCAP: begin
        byte_d = mem_rdata[8*byte_addr[1:0] +: 8];
        st_d   = ST_BOUT;
      end
      ST_BOUT: begin
        out_valid = 1'b1;
        if (out_ready) begin
          cnt_d = cnt_q + 1'b1;
          if (!fin) st_d = ST_BREQ;
          else if (cmd_q[CMD_RS]) st_d = ST_WB;
          else st_d = ST_ADV;
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(12);
        mem_be    = 4'b0001;
        mem_wdata = 32'(1) << STS_DONE;
        st_d      = ST_ADV;
      end
      ST_ADV: begin
        head_adv = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      buf_q  <= '0;
      len_q  <= '0;
      cmd_q  <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
    end else begin
      st_q   <= st_d;
      buf_q  <= buf_d;
      len_q  <= len_d;
      cmd_q  <= cmd_d;
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign out_data = byte_q;
  assign out_last = out_valid && cmd_q[CMD_EOP] && fin;

  // R6: a stalled byte holds its data and last flag
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R7: last never appears without a valid byte
  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R8: the status write touches only the status byte and sets done
  p_wb_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be == 4'b0001 && mem_wdata[STS_DONE]));
  // R8 R10: the status write follows the final accepted byte or an empty descriptor
  p_wb_after_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($past(out_valid && out_ready) || $past(st_q) == ST_F3));
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 16,
  parameter int LW   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last
);
  logic [1:0]      rst_sync_q;
  logic            rst_n_i;
  logic            en, busy, head_adv;
  logic [AW-1:0]   ring_base, mem_addr_i;
  logic [IDXW-1:0] head, tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  txr_regs #(.AW(AW), .IDXW(IDXW)) regs_i (
    .clk(clk), .rst_n(rst_n_i),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .head_adv(head_adv),
    .en(en), .ring_base(ring_base), .head(head), .tail(tail)
  );

  txr_ctrl #(.AW(AW), .IDXW(IDXW), .LW(LW)) ctrl_i (
    .clk(clk), .rst_n(rst_n_i),
    .en(en), .ring_base(ring_base), .head(head), .tail(tail),
    .head_adv(head_adv), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr_i), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  assign mem_addr = 32'(mem_addr_i);

  // R1: the engine stays off the memory port while reset is held
  p_quiet_reset_r1: assert property (@(posedge clk) !rst_n_i |-> !mem_req && !out_valid);
endmodule

// File: tb/txring_engine_tb_top.sv
`timescale 1ns/1ps
module txring_engine_tb_top;
  localparam int MW      = 512;
  localparam logic [31:0] BASE = 32'h100;
  localparam int NENT    = 8;
  localparam int WDOG    = 150000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, reg_wr, mem_req, mem_we, out_valid, out_ready, out_last;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [7:0]  out_data;

  logic        host_wr;
  logic [31:0] host_addr, host_data;
  logic [3:0]  host_be;

  logic [31:0] mem [0:MW-1];
  logic [8:0]  exp_q[$];
  int unsigned rx_count, post_cum, cyc;
  int unsigned cum_at [NENT];
  bit          rs_at [NENT];
  int          checks, fails;
  bit          finished;
  int unsigned sw_tail, buf_ptr;
  logic [31:0] rv;

  txring_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int unsigned slot, input int unsigned i,
                                     input int unsigned rnd);
    return 8'((slot * 37 + i * 11 + rnd * 5) ^ 32'h5A);
  endfunction

  // memory model, stream monitor, status-write monitor
  always @(posedge clk) begin
    cyc++;
    if (host_wr) begin
      for (int b = 0; b < 4; b++)
        if (host_be[b]) mem[host_addr[31:2]][8*b +: 8] = host_data[8*b +: 8];
    end
    if (rst_n && mem_req) begin
      if (mem_we) begin
        int unsigned idx;
        idx = (mem_addr - BASE) >> 4;
        chk(mem_addr[3:0] == 4'hC && idx < NENT, "R8", "status write address", mem_addr, 32'hC);
        if (idx < NENT) begin
          chk(rx_count == cum_at[idx], "R8", "bytes accepted before done write", rx_count, cum_at[idx]);
          chk(rs_at[idx], "R8", "done write without report request", 0, 1);
        end
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[31:2]][8*b +: 8] = mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[31:2]];
      end
    end
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected stream byte", out_data, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(out_data == e[7:0], "R6", "stream byte", out_data, e[7:0]);
        chk(out_last == e[8], "R7", "last flag", out_last, e[8]);
      end
      rx_count++;
    end
  end

  always @(negedge clk) out_ready <= ($urandom % 4) != 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc == WDOG && !finished) begin
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WDOG);
    summary();
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic host_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); host_wr = 1; host_addr = a; host_data = d; host_be = be;
    @(negedge clk); host_wr = 0;
  endtask

  // place one descriptor (cmd bit 0 end of packet, bit 3 report status)
  task automatic post_desc(input int unsigned len, input logic [7:0] cmd, input int unsigned rnd);
    int unsigned slot, ba;
    slot = sw_tail;
    ba = buf_ptr + ($urandom % 4);
    for (int i = 0; i < int'(len); i++) begin
      logic [31:0] a;
      logic [7:0]  v;
      a = ba + i;
      v = pat(slot, i, rnd);
      host_write(a, {4{v}}, 4'b0001 << a[1:0]);
      exp_q.push_back({(cmd[0] && i == int'(len) - 1), v});
    end
    host_write(BASE + slot * 16 + 0,  ba, 4'hF);
    host_write(BASE + slot * 16 + 4,  32'h0, 4'hF);
    host_write(BASE + slot * 16 + 8,  {cmd, 8'h00, 16'(len)}, 4'hF);
    host_write(BASE + slot * 16 + 12, 32'h0, 4'hF);
    post_cum += len;
    cum_at[slot] = post_cum;
    rs_at[slot]  = cmd[3];
    buf_ptr = ba + len + 8;
    sw_tail = (sw_tail + 1) % NENT;
  endtask

  task automatic drain_and_check(input int unsigned first, input int unsigned n, input string tag);
    logic [31:0] h;
    reg_write(3'd4, sw_tail);
    h = 32'hFFFF_FFFF;
    for (int i = 0; i < 3000 && h != sw_tail; i++) reg_read(3'd3, h);
    repeat (4) @(negedge clk);
    chk(h == sw_tail, tag, "head reaches tail", h, sw_tail);
    chk(rx_count == post_cum && exp_q.size() == 0, "R4", "all bytes streamed", rx_count, post_cum);
    for (int k = 0; k < int'(n); k++) begin
      int unsigned s;
      s = (first + k) % NENT;
      chk(mem[(BASE + s * 16 + 12) >> 2][0] == rs_at[s], "R8", "done bit vs report request",
          mem[(BASE + s * 16 + 12) >> 2][0], rs_at[s]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    host_wr = 0; host_addr = 0; host_data = 0; host_be = 0;
    checks = 0; fails = 0; finished = 0; rx_count = 0; post_cum = 0; cyc = 0;
    sw_tail = 0; buf_ptr = 32'h400; mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), rv);
      chk(rv == 0, "R1", "register after reset", rv, 0);
    end
    chk(!out_valid && !mem_req, "R1", "idle outputs after reset", {out_valid, mem_req}, 0);

    // R2 register map, length granularity
    reg_write(3'd1, BASE);
    reg_read(3'd1, rv); chk(rv == BASE, "R2", "base readback", rv, BASE);
    reg_write(3'd2, 32'hFF);
    reg_read(3'd2, rv); chk(rv == 32'h80, "R2", "length rounded to 128", rv, 32'h80);

    // R11 head writable while disabled and idle
    reg_write(3'd3, 32'd5);
    reg_read(3'd3, rv); chk(rv == 5, "R11", "head write while disabled", rv, 5);
    reg_write(3'd3, 32'd0);

    // R7 multi-descriptor frame, R5 layout; posted while disabled (R3)
    post_desc(4, 8'h00, 0);
    post_desc(5, 8'h09, 0);
    reg_write(3'd4, sw_tail);
    repeat (40) @(negedge clk);
    chk(rx_count == 0, "R3", "no bytes while disabled", rx_count, 0);
    reg_read(3'd3, rv); chk(rv == 0, "R3", "head unchanged while disabled", rv, 0);
    reg_read(3'd4, rv); chk(rv == 2, "R3", "tail accepted while disabled", rv, 2);

    reg_write(3'd0, 32'h1);
    reg_read(3'd0, rv); chk(rv == 1, "R2", "enable readback", rv, 1);
    drain_and_check(0, 2, "R4");

    // R11 head write ignored while enabled
    reg_write(3'd3, 32'd6);
    reg_read(3'd3, rv); chk(rv == sw_tail, "R11", "head write ignored while enabled", rv, sw_tail);

    // R10 zero-length descriptors, with and without report
    begin
      int unsigned f;
      f = sw_tail;
      buf_ptr = 32'h400;
      post_desc(0, 8'h09, 1);
      post_desc(3, 8'h01, 1);
      post_desc(0, 8'h00, 1);
      post_desc(1, 8'h09, 1);
      drain_and_check(f, 4, "R10");
    end

    // random rounds covering wrap-around (R9) and back-pressure (R6)
    for (int rnd = 2; rnd < 14; rnd++) begin
      int unsigned n, f;
      f = sw_tail;
      n = 1 + ($urandom % (NENT - 1));
      buf_ptr = 32'h400;
      for (int k = 0; k < int'(n); k++) begin
        logic [7:0] c;
        c = 8'h00;
        c[0] = ($urandom % 3) != 0;
        c[3] = $urandom % 2;
        post_desc($urandom % 13, c, rnd);
      end
      drain_and_check(f, n, "R9");
    end

    summary();
  end
endmodule